// File: doc/BRIEF.md
# Serial Transmit Port Handshake Controller

This block sits between a host and the modulator of a spread-spectrum baseband transmitter. The host starts a packet by driving a packet-enable strobe to its active level and holds it there for the whole packet. While the strobe is active, the block produces a serial bit clock that is derived from the system clock. On each falling edge of that clock it takes one bit, and it hands each bit to the modulator as a single-cycle strobe together with the bit value. The host changes its data on the rising edge of the bit clock.

The block has two modes. In internal mode it first sends a fixed-length preamble and then a header of selectable length. The preamble repeats a small bit pattern, and the header comes from a configuration word. The host is then asked for payload through a ready flag. That flag can be raised a programmable number of bit periods early. In external mode the host supplies preamble and header itself. Host bits are forwarded from the first bit-clock period, and the ready flag is never raised.

The packet-enable, ready and bit-clock pins each have their own polarity control. A clear-channel flag from the receiver is accepted but has no effect on transmission.

Top module: `tx_port_ctrl`

## Requirements
- R1: Whenever the block is idle and packet-enable becomes active, a transmission starts, whatever the level of `cca_clear`. The bit clock's first transition to its active level comes HALF_DIV system clocks after the enable is first sampled.
- R2: The bit clock toggles every HALF_DIV system clocks, only while packet-enable is active. Otherwise it rests at its inactive level: 0, or 1 when `bclk_low` is set.
- R3: Exactly one bit is emitted per bit-clock period. `bit_vld` pulses for one system clock, and successive pulses are 2*HALF_DIV clocks apart. In the payload phase, `bit_out` carries `txd_in` as sampled at the bit clock's falling edge.
- R4: The internal-mode bit order is as follows. First come PRE_LEN preamble bits, where bit i equals `pre_pat[i mod PAT_W]`. Next come `hdr_len` header bits, taken from `hdr_word` starting at bit 0. A `hdr_len` above HDR_W counts as HDR_W. After that, payload bits follow in the order they were sampled.
- R5: In internal mode, ready turns active once the number of preamble and header bits still to be sent is at most `rdy_lead`. With `rdy_lead` = 0, this happens together with the last header bit. Ready then stays active until packet-enable goes inactive.
- R6: In external mode, the first emitted bit is the first sampled `txd_in` bit, and every later bit is host data. Ready stays at its inactive level for the whole packet.
- R7: `pe_low`, `rdy_low` and `bclk_low` each invert only their own pin. A set bit makes that pin active-low.
- R8: If packet-enable goes inactive during preamble or header, the block aborts. No further bits are emitted, the bit clock stops, and the next packet restarts at preamble bit 0.
- R9: If packet-enable goes inactive during payload, the block returns to idle after the last captured bit. No further bits are emitted, and ready returns to its inactive level.
- R10: In internal mode with `hdr_len` = 0, payload follows the last preamble bit directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pe_in | input | 1 | Packet-enable strobe from the host (polarity per `pe_low`) |
| txd_in | input | 1 | Serial data from the host |
| int_mode | input | 1 | 1 = internal preamble and header, 0 = external pass-through |
| pre_pat | input | PAT_W | Repeating preamble pattern, bit 0 sent first |
| hdr_word | input | HDR_W | Header bits, bit 0 sent first |
| hdr_len | input | $clog2(HDR_W+1) | Number of header bits |
| rdy_lead | input | $clog2(PRE_LEN+HDR_W+1) | Ready advance in bit periods |
| pe_low | input | 1 | Packet-enable is active-low |
| rdy_low | input | 1 | Ready is active-low |
| bclk_low | input | 1 | Bit clock is inverted |
| cca_clear | input | 1 | Clear-channel flag, informational only |
| bclk_out | output | 1 | Serial bit clock to the host |
| rdy_out | output | 1 | Ready for payload |
| bit_out | output | 1 | Serial bit to the modulator |
| bit_vld | output | 1 | One-cycle strobe marking `bit_out` |

## Verification
The assertions assume the following about the inputs. The mode, header, pattern, lead and polarity inputs change only while the block is idle. Packet-enable is a level that is held for at least a whole bit period before any change. The host data changes only after a rising edge of the bit clock, never near a falling edge.

The directed tasks set every configuration input before they raise packet-enable. They update `txd_in` on the system-clock falling edge right after a bit is captured, which leaves it stable for a full bit period. They drop packet-enable only right after a captured bit, and they wait twenty clocks of idle before the next packet.

// File: rtl/tx_port_ctrl.sv
module tx_port_ctrl #(
  parameter int HALF_DIV = 2,
  parameter int PRE_LEN  = 16,
  parameter int PAT_W    = 4,
  parameter int HDR_W    = 16,
  localparam int HLW = $clog2(HDR_W + 1),
  localparam int RW  = $clog2(PRE_LEN + HDR_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pe_in,
  input  logic             txd_in,
  input  logic             int_mode,
  input  logic [PAT_W-1:0] pre_pat,
  input  logic [HDR_W-1:0] hdr_word,
  input  logic [HLW-1:0]   hdr_len,
  input  logic [RW-1:0]    rdy_lead,
  input  logic             pe_low,
  input  logic             rdy_low,
  input  logic             bclk_low,
  input  logic             cca_clear,
  output logic             bclk_out,
  output logic             rdy_out,
  output logic             bit_out,
  output logic             bit_vld
);

  localparam int CW  = $clog2(HALF_DIV + 1);
  localparam int PIW = $clog2(PAT_W);
  localparam int HIW = $clog2(HDR_W);
  localparam logic [HLW-1:0] HL_MAX = HLW'(HDR_W);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_HDR, S_DATA} st_t;

  st_t            st;
  logic [CW-1:0]  div_cnt;
  logic           bclk_i;
  logic [RW-1:0]  idx;
  logic [HDR_W-1:0] hdr_q;
  logic [HLW-1:0] hl_q;
  logic           mode_q;

  wire pe_act   = pe_in ^ pe_low;
  wire half_end = (st != S_IDLE) && (div_cnt == CW'(HALF_DIV - 1));
  wire tick     = half_end && bclk_i;
  wire [HLW-1:0] hl_in = (hdr_len > HL_MAX) ? HL_MAX : hdr_len;
  wire [RW-1:0] rem = (st == S_PRE) ? (RW'(PRE_LEN) - idx + RW'(hl_q))
                                    : (RW'(hl_q) - idx);
  wire pre_last = (idx == RW'(PRE_LEN - 1));
  wire hdr_last = ((idx + RW'(1)) == RW'(hl_q));
  wire rdy_i = mode_q && ((st == S_DATA) ||
               ((st == S_PRE || st == S_HDR) && (rem <= rdy_lead)));

  assign bclk_out = bclk_i ^ bclk_low;
  assign rdy_out  = rdy_i ^ rdy_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      div_cnt <= '0;
      bclk_i  <= 1'b0;
      idx     <= '0;
      hdr_q   <= '0;
      hl_q    <= '0;
      mode_q  <= 1'b0;
      bit_out <= 1'b0;
      bit_vld <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (st == S_IDLE) begin
        div_cnt <= '0;
        bclk_i  <= 1'b0;
        idx     <= '0;
        if (pe_act) begin
          mode_q <= int_mode;
          hdr_q  <= hdr_word;
          hl_q   <= hl_in;
          st     <= int_mode ? S_PRE : S_DATA;
        end
      end else if (!pe_act) begin
        st      <= S_IDLE;
        div_cnt <= '0;
        bclk_i  <= 1'b0;
        idx     <= '0;
      end else begin
        if (half_end) begin
          div_cnt <= '0;
          bclk_i  <= ~bclk_i;
        end else begin
          div_cnt <= div_cnt + CW'(1);
        end
        if (tick) begin
          bit_vld <= 1'b1;
          case (st)
            S_PRE: begin
              bit_out <= pre_pat[idx[PIW-1:0]];
              if (pre_last) begin
                idx <= '0;
                st  <= (hl_q == '0) ? S_DATA : S_HDR;
              end else begin
                idx <= idx + RW'(1);
              end
            end
            S_HDR: begin
              bit_out <= hdr_q[idx[HIW-1:0]];
              if (hdr_last) begin
                idx <= '0;
                st  <= S_DATA;
              end else begin
                idx <= idx + RW'(1);
              end
            end
            default: bit_out <= txd_in;
          endcase
        end
      end
    end
  end

  assert_start_ignores_cca_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pe_act && !cca_clear) |=> (st != S_IDLE));

  assert_clock_rests_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_act |=> (bclk_out == bclk_low));

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld);

  assert_bits_within_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |-> $past(pe_act));

  assert_ready_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_i && pe_act) |=> rdy_i);

  assert_ext_ready_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && pe_act && !int_mode) |=> (rdy_out == rdy_low));

endmodule

// File: tb/tx_port_ctrl_tb.sv
`timescale 1ns/1ps
module tx_port_ctrl_tb;
  localparam int HALF = 2;
  localparam int PRE  = 16;
  localparam int PW   = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, pe_in, txd_in, int_mode, pe_low, rdy_low, bclk_low, cca_clear;
  logic [3:0]  pre_pat;
  logic [15:0] hdr_word;
  logic [4:0]  hdr_len;
  logic [5:0]  rdy_lead;
  logic bclk_out, rdy_out, bit_out, bit_vld;

  tx_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pe_in(pe_in), .txd_in(txd_in), .int_mode(int_mode),
    .pre_pat(pre_pat), .hdr_word(hdr_word), .hdr_len(hdr_len), .rdy_lead(rdy_lead),
    .pe_low(pe_low), .rdy_low(rdy_low), .bclk_low(bclk_low), .cca_clear(cca_clear),
    .bclk_out(bclk_out), .rdy_out(rdy_out), .bit_out(bit_out), .bit_vld(bit_vld)
  );

  int n_chk = 0, n_bad = 0;
  logic [255:0] got;
  int ngot, rdy_at, tot, cyc_now, last_vld;
  bit rdy_seen, rdy_drop, gap_bad;
  logic [63:0] pay = 64'hA5C3_1F0E_9B27_6D48;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc_now++;
    if (bit_vld) begin
      if (ngot > 0 && (cyc_now - last_vld) != 2 * HALF) gap_bad = 1;
      last_vld = cyc_now;
      if (ngot < 256) got[ngot] = bit_out;
      ngot++;
    end
    if (rdy_out ^ rdy_low) begin
      if (rdy_at < 0) rdy_at = ngot;
      rdy_seen = 1;
    end else if (rdy_seen && ((pe_in ^ pe_low) == 1'b1)) begin
      rdy_drop = 1;
    end
    txd_in = (ngot >= tot) ? pay[(ngot - tot) % 64] : 1'b0;
  endtask

  function automatic logic exp_bit(input int k, input int hlc);
    if (k < tot) begin
      if (k < PRE) return pre_pat[k % PW];
      return hdr_word[k - PRE];
    end
    return pay[(k - tot) % 64];
  endfunction

  task automatic pkt(input string name, input bit intm, input int hl, input int lead,
                     input int npay, input int abort_at, input string req_s);
    int hlc, stop, nstop, cyc, mism, nexp;
    hlc = (hl > 16) ? 16 : hl;
    tot = intm ? PRE + hlc : 0;
    int_mode = intm; hdr_len = 5'(hl); rdy_lead = 6'(lead);
    ngot = 0; rdy_at = -1; rdy_seen = 0; rdy_drop = 0; gap_bad = 0;
    txd_in = (tot == 0) ? pay[0] : 1'b0;
    @(negedge clk);
    pe_in = ~pe_low;
    stop = (abort_at >= 0) ? abort_at : tot + npay + 3;
    cyc = 0;
    while (ngot < stop && cyc < 5000) begin step(); cyc++; end
    pe_in = pe_low;
    nstop = ngot;
    repeat (20) step();
    chk(ngot == nstop, (abort_at >= 0) ? "R8" : "R9", {name, " bits after enable drop"}, ngot, nstop);
    chk(bclk_out == bclk_low, "R2", {name, " bit clock idle level"}, bclk_out, bclk_low);
    chk(rdy_out == rdy_low, "R9", {name, " ready idle level"}, rdy_out, rdy_low);
    chk(!gap_bad, "R3", {name, " bit spacing"}, gap_bad, 0);
    nexp = (abort_at >= 0) ? abort_at : tot + npay;
    mism = -1;
    for (int k = 0; k < nexp; k++)
      if (mism < 0 && got[k] !== exp_bit(k, hlc)) mism = k;
    chk(mism < 0, req_s, {name, " stream first bad index"}, mism, -1);
    if (intm && abort_at < 0) begin
      chk(rdy_at == ((tot - lead) > 0 ? tot - lead : 0), "R5", {name, " ready lead"},
          rdy_at, (tot - lead) > 0 ? tot - lead : 0);
      chk(!rdy_drop, "R5", {name, " ready held"}, rdy_drop, 0);
    end
    if (!intm) chk(!rdy_seen, "R6", {name, " ready stays inactive"}, rdy_seen, 0);
  endtask

  task automatic bclk_timing();
    int c;
    int_mode = 1; hdr_len = 5'd4; rdy_lead = 6'd0; cca_clear = 1'b0;
    ngot = 0; tot = PRE + 4; rdy_at = -1; rdy_seen = 0;
    @(negedge clk);
    pe_in = ~pe_low;
    c = 0;
    do begin step(); c++; end while (bclk_out == bclk_low && c < 50);
    chk(c == HALF + 1, "R1", "first bit clock edge despite busy channel", c, HALF + 1);
    c = 0;
    do begin step(); c++; end while (bclk_out != bclk_low && c < 50);
    chk(c == HALF, "R2", "bit clock half period", c, HALF);
    pe_in = pe_low;
    repeat (20) step();
    chk(bclk_out == bclk_low, "R8", "clock stops after early drop", bclk_out, bclk_low);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; pe_in = 0; txd_in = 0; int_mode = 1; pe_low = 0; rdy_low = 0;
    bclk_low = 0; cca_clear = 1; pre_pat = 4'b0110; hdr_word = 16'hC3A9;
    hdr_len = 5'd8; rdy_lead = 6'd0; cyc_now = 0; last_vld = 0; tot = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bclk_out == 1'b0, "R2", "reset bit clock", bclk_out, 0);
    chk(rdy_out == 1'b0, "R5", "reset ready", rdy_out, 0);
    chk(bit_vld == 1'b0, "R3", "reset strobe", bit_vld, 0);

    bclk_timing();
    pkt("int hl8",    1, 8,  0,  20, -1, "R4");
    pkt("int lead5",  1, 12, 5,  16, -1, "R4");
    pkt("int nohdr",  1, 0,  0,  12, -1, "R10");
    pkt("int clamp",  1, 20, 40, 10, -1, "R4");
    cca_clear = 0;
    pkt("ext",        0, 8,  3,  30, -1, "R6");
    cca_clear = 1;
    pkt("abort",      1, 8,  0,  10, 10, "R8");
    pkt("after abort",1, 6,  2,  8,  -1, "R8");
    pe_low = 1; rdy_low = 1; bclk_low = 1; pe_in = 1;
    repeat (3) @(negedge clk);
    chk(bclk_out == 1'b1 && rdy_out == 1'b1, "R7", "inverted idle levels",
        {bclk_out, rdy_out}, 3);
    pkt("inverted",   1, 4,  3,  14, -1, "R7");
    pkt("inv ext",    0, 4,  0,  9,  -1, "R7");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule